// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block issues clause-22 management transactions toward Ethernet PHYs from a single 32-bit command word. The host writes the word, which holds an opcode, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The engine then serialises a frame on the management clock and data lines. For a read, it releases the data line and shifts in the PHY's answer.

When the frame ends, the engine sets a completion flag inside that same word, and the host polls for it. For a read, the low half of the word then holds the returned value. Read data comes from one of two serial inputs. One serves the on-board PHY and one serves a PHY on an external connector; the PHY address picks between them, and any other address reads back as zero. The management clock is the system clock divided by a fixed parameter, and one full management clock period carries one bit.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset the status word is all zeros, `mdc` is high and `mdio_oe` is low; while no transaction runs, `mdc` stays high and `mdio_oe` low.
- R2: Each transaction opens with `PRE_LEN` (default 32) bit times of `mdio_out` = 1 with `mdio_oe` = 1.
- R3: After the preamble the frame carries the start pattern `01`, then command bits 29:28 as the opcode, then the PHY address from command bits 27:23, then the register address from command bits 22:18, each field MSB first.
- R4: For any opcode other than `10`, the register address is followed by 16 data bits from command bits 15:0, MSB first, with `mdio_oe` high throughout, so the frame is `PRE_LEN`+30 bits long.
- R5: Opcode `10` is a read: `mdio_oe` drops after the last register-address bit, one turnaround bit time passes, and then 16 bits are captured MSB first, so the frame is `PRE_LEN`+31 bits long.
- R6: A bit time is `CLK_DIV` system cycles with `mdc` low followed by `CLK_DIV` cycles with `mdc` high. `mdio_out` changes only while `mdc` is low. Read data is captured on the last low cycle, at the edge that raises `mdc`.
- R7: At the end of a frame, bit 16 of the status word becomes 1 and stays 1 until the next accepted command. Bits 31:17 echo the accepted command. Bits 15:0 hold the captured read data after a read and the written data after any other opcode.
- R8: Read bits come from `mdio_in_int` when the PHY address equals `INT_PHY_ADDR` (default 1). They come from `mdio_in_ext` when it equals `EXT_PHY_ADDR` (default 0). Any other address returns zeros, and if the two parameters are equal the internal input wins.
- R9: A command write that arrives while a transaction runs, including the cycle in which that transaction completes, changes neither the frame nor the status word.
- R10: A command is accepted only while idle. Acceptance clears bit 16 in the next cycle, whatever value bit 16 had in the written word.
- R11: Bit 16 becomes visible exactly 2·`CLK_DIV`·(frame length) clock edges after the edge that accepted the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word: opcode 29:28, PHY 27:23, register 22:18, data 15:0 |
| cmd_rdata | output | 32 | Status word: command echo 31:17, completion 16, data 15:0 |
| mdc | output | 1 | Management clock, idle high |
| mdio_out | output | 1 | Serial data driven toward the PHYs |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| mdio_in_int | input | 1 | Serial data returned by the on-board PHY |
| mdio_in_ext | input | 1 | Serial data returned by the external PHY |

## Verification
Two functions can meet in one cycle: the completion of a running frame and the acceptance logic facing a host write. The bench provokes this by holding the strobe high with a different command for the whole of a read, so a write is presented on the very edge that sets the completion bit. The check is that the status word at that moment still shows the read's echo and returned data, and that the pending command is taken only on the following edge, with the completion bit cleared. The captured frame that follows must be the second command's write frame, not a blend of the two.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int WORD_W = 32;

    // start pattern + opcode + two addresses
    localparam int HDR_FIELD_BITS = 2 + 2 + 2 * ADDR_W;

    localparam logic [1:0] START_PAT = 2'b01;

    typedef enum logic [1:0] {
        OP_RSVD_LO = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_RSVD_HI = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic [1:0]        spare_hi;
        mdio_op_e          op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic              spare_lo;
        logic              done;
        logic [DATA_W-1:0] data;
    } cmd_word_t;

    function automatic logic op_is_read(input mdio_op_e op);
        return op == OP_READ;
    endfunction

    // Frame body after the preamble, MSB sent first
    function automatic logic [HDR_FIELD_BITS+DATA_W-1:0] frame_body(input cmd_word_t c);
        return {START_PAT, c.op, c.phy, c.regad, c.data};
    endfunction

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic sample_en,
    output logic bit_done
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int CNT_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == CNT_W'(PERIOD - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // low half first, then high half; idle high
    assign mdc       = !run || (cnt >= CNT_W'(HALF_DIV));
    assign sample_en = run && (cnt == CNT_W'(HALF_DIV - 1));
    assign bit_done  = run && (cnt == CNT_W'(PERIOD - 1));

endmodule

// File: rtl/mdio_frame_tx.sv
module mdio_frame_tx #(
    parameter int FRAME_W = 62,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               shift,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               bit_out,
    output logic [IDX_W-1:0]   bit_idx
);
    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '1;
            bit_idx <= '0;
        end else if (load) begin
            sr      <= frame_in;
            bit_idx <= '0;
        end else if (shift) begin
            sr      <= {sr[FRAME_W-2:0], 1'b1};
            bit_idx <= bit_idx + IDX_W'(1);
        end
    end

    assign bit_out = sr[FRAME_W-1];

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
    parameter int                DATA_W   = 16,
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] INT_ADDR = 5'd1,
    parameter logic [ADDR_W-1:0] EXT_ADDR = 5'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic [ADDR_W-1:0] phy,
    input  logic              pin_int,
    input  logic              pin_ext,
    output logic [DATA_W-1:0] data
);
    logic sel_bit;

    // internal address has priority over external
    always_comb begin
        if (phy == INT_ADDR) begin
            sel_bit = pin_int;
        end else if (phy == EXT_ADDR) begin
            sel_bit = pin_ext;
        end else begin
            sel_bit = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            data <= '0;
        end else if (sample) begin
            data <= {data[DATA_W-2:0], sel_bit};
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int          CLK_DIV      = 4,
    parameter int          PRE_LEN      = 32,
    parameter logic [4:0]  INT_PHY_ADDR = 5'd1,
    parameter logic [4:0]  EXT_PHY_ADDR = 5'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in_int,
    input  logic        mdio_in_ext
);
    localparam int HDR_BITS = PRE_LEN + HDR_FIELD_BITS;
    localparam int WR_BITS  = HDR_BITS + DATA_W;
    localparam int RD_BITS  = HDR_BITS + 1 + DATA_W;
    localparam int IDX_W    = $clog2(RD_BITS + 1);

    cmd_word_t         new_cmd;
    cmd_word_t         cmd_q;
    logic              busy;
    logic              accept;
    logic              is_rd;
    logic              sample_en;
    logic              bit_done;
    logic              last_bit;
    logic              rx_sample;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] rd_data;
    logic [WR_BITS-1:0] frame_vec;

    assign new_cmd   = cmd_word_t'(cmd_wdata);
    assign accept    = cmd_wr && !busy;
    assign is_rd     = op_is_read(cmd_q.op);
    assign frame_vec = {{PRE_LEN{1'b1}}, frame_body(new_cmd)};
    assign last_bit  = bit_idx == (is_rd ? IDX_W'(RD_BITS - 1) : IDX_W'(WR_BITS - 1));
    assign rx_sample = sample_en && is_rd && (bit_idx > IDX_W'(HDR_BITS));

    mdio_bit_timer #(
        .HALF_DIV (CLK_DIV)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .mdc       (mdc),
        .sample_en (sample_en),
        .bit_done  (bit_done)
    );

    mdio_frame_tx #(
        .FRAME_W (WR_BITS),
        .IDX_W   (IDX_W)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .shift    (bit_done),
        .frame_in (frame_vec),
        .bit_out  (mdio_out),
        .bit_idx  (bit_idx)
    );

    mdio_rx_capture #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .INT_ADDR (INT_PHY_ADDR),
        .EXT_ADDR (EXT_PHY_ADDR)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .sample  (rx_sample),
        .phy     (cmd_q.phy),
        .pin_int (mdio_in_int),
        .pin_ext (mdio_in_ext),
        .data    (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cmd_q <= '0;
        end else if (accept) begin
            busy       <= 1'b1;
            cmd_q      <= new_cmd;
            cmd_q.done <= 1'b0;
        end else if (busy && bit_done && last_bit) begin
            busy       <= 1'b0;
            cmd_q.done <= 1'b1;
            if (is_rd) begin
                cmd_q.data <= rd_data;
            end
        end
    end

    assign mdio_oe   = busy && (!is_rd || (bit_idx < IDX_W'(HDR_BITS)));
    assign cmd_rdata = cmd_q;

endmodule

// File: rtl/mdio_frame_chk.sv
module mdio_frame_chk #(
    parameter int IDX_W    = 6,
    parameter int PRE_LEN  = 32,
    parameter int HDR_BITS = 46
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_wr,
    input logic             busy,
    input logic             is_rd,
    input logic [IDX_W-1:0] bit_idx,
    input logic             mdc,
    input logic             mdio_oe,
    input logic             mdio_out,
    input logic [31:0]      cmd_rdata
);
    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdc && !mdio_oe));

    // R2
    preamble_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (bit_idx < IDX_W'(PRE_LEN))) |-> (mdio_oe && mdio_out));

    // R4
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_rd) |-> mdio_oe);

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && is_rd && (bit_idx >= IDX_W'(HDR_BITS))) |-> !mdio_oe);

    // R6
    data_change_low_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(mdio_out)) |-> !mdc);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_rdata[16] && !cmd_wr) |=> cmd_rdata[16]);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> $stable(cmd_rdata[31:17]));

    // R10
    accept_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy) |=> (!cmd_rdata[16] && busy));

endmodule

bind mdio_frame_engine mdio_frame_chk #(
    .IDX_W    (IDX_W),
    .PRE_LEN  (PRE_LEN),
    .HDR_BITS (HDR_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .busy      (busy),
    .is_rd     (is_rd),
    .bit_idx   (bit_idx),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .mdio_out  (mdio_out),
    .cmd_rdata (cmd_rdata)
);

// File: tb/mdio_frame_engine_tb.sv
module mdio_frame_engine_tb;

    localparam int HALF   = 2;
    localparam int WR_LEN = 62;
    localparam int RD_LEN = 63;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_wr;
    logic [31:0] cmd_wdata;
    logic [31:0] cmd_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        pin_int = 1'b1;
    logic        pin_ext = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    mdio_frame_engine #(
        .CLK_DIV (HALF)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (cmd_wr),
        .cmd_wdata   (cmd_wdata),
        .cmd_rdata   (cmd_rdata),
        .mdc         (mdc),
        .mdio_out    (mdio_out),
        .mdio_oe     (mdio_oe),
        .mdio_in_int (pin_int),
        .mdio_in_ext (pin_ext)
    );

    function automatic logic [15:0] reg_val(input logic [4:0] p, input logic [4:0] r);
        return 16'((32'(p) * 32'h0421) ^ (32'(r) * 32'h1357) ^ 32'hA5C3);
    endfunction

    // R8 expectation: internal PHY at 1, external at 0 (its pin carries the inverse)
    function automatic logic [15:0] exp_read(input logic [4:0] p, input logic [4:0] r);
        if (p == 5'd1) return reg_val(p, r);
        if (p == 5'd0) return ~reg_val(p, r);
        return 16'h0000;
    endfunction

    function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
        return {2'b00, op, p, r, 1'b0, 1'b0, d};
    endfunction

    // PHY model: records driven bits on rising mdc, answers reads
    logic [63:0] cap  = '0;
    int          ncap = 0;
    int          rcnt = 0;
    logic [15:0] drv_word = '0;

    always @(posedge mdc or posedge mdio_oe) begin
        if (!mdc) begin
            cap  = '0;
            ncap = 0;
            rcnt = 0;
        end else if (mdio_oe) begin
            cap  = {cap[62:0], mdio_out};
            ncap = ncap + 1;
        end else begin
            if (rcnt == 0) drv_word = reg_val(cap[9:5], cap[4:0]);
            if (rcnt < 16) begin
                #1;
                pin_int = drv_word[15-rcnt];
                pin_ext = ~drv_word[15-rcnt];
            end
            rcnt = rcnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic [31:0] w, output int cyc,
                           output logic [7:0] trace, output logic done0);
        @(negedge clk);
        cmd_wdata = w;
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        done0  = cmd_rdata[16];
        cyc    = 0;
        trace  = '0;
        while (!cmd_rdata[16] && cyc < 4000) begin
            if (cyc < 8) trace[cyc] = mdc;
            @(negedge clk);
            cyc++;
        end
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog R11: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int          cyc;
        logic [7:0]  tr;
        logic        d0;
        logic [31:0] w;
        logic [31:0] w2;
        logic [15:0] dv;
        logic [61:0] wf;

        rst       = 1'b1;
        cmd_wr    = 1'b0;
        cmd_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_rdata == 32'h0 && mdc && !mdio_oe, "R1 reset state",
              {cmd_rdata, 29'h0, mdc, mdio_oe, 1'b0}, {32'h0, 29'h0, 3'b100});

        // read sweep over every PHY address
        for (int p = 0; p < 32; p++) begin
            logic [4:0] pa;
            logic [4:0] ra;
            pa = 5'(p);
            ra = 5'((p * 7 + 3) % 32);
            w  = mk_cmd(2'b10, pa, ra, 16'h0);
            run_txn(w, cyc, tr, d0);
            check(cmd_rdata[15:0] == exp_read(pa, ra), "R8 read data by address",
                  64'(cmd_rdata[15:0]), 64'(exp_read(pa, ra)));
            check(cmd_rdata[31:16] == {w[31:17], 1'b1}, "R7 echo and done",
                  64'(cmd_rdata[31:16]), 64'({w[31:17], 1'b1}));
            check(ncap == 46 && cap[45:14] == 32'hFFFF_FFFF, "R2 preamble",
                  {32'(ncap), cap[45:14]}, {32'd46, 32'hFFFF_FFFF});
            check(cap[13:0] == {2'b01, 2'b10, pa, ra}, "R3 header fields",
                  64'(cap[13:0]), 64'({2'b01, 2'b10, pa, ra}));
            check(cyc == RD_LEN * 2 * HALF, "R11 read duration",
                  64'(cyc), 64'(RD_LEN * 2 * HALF));
            check(rcnt == 17, "R5 turnaround plus data bit times",
                  64'(rcnt), 64'd17);
            if (p < 2) begin
                check(tr == 8'b1100_1100, "R6 mdc low/high halves",
                      64'(tr), 64'h00CC);
                check(d0 == 1'b0, "R10 done cleared on accept", 64'(d0), 64'd0);
            end
        end

        // write sweep over every register address, several opcodes
        for (int r = 0; r < 32; r++) begin
            logic [4:0] pa;
            logic [4:0] ra;
            logic [1:0] op;
            pa = 5'((r * 5) % 32);
            ra = 5'(r);
            op = (r % 3 == 0) ? 2'b00 : ((r % 3 == 1) ? 2'b01 : 2'b11);
            dv = 16'((r * 32'h0B0D) ^ 32'h5A5A);
            w  = mk_cmd(op, pa, ra, dv);
            if (r == 5) w[16] = 1'b1;
            run_txn(w, cyc, tr, d0);
            wf = {32'hFFFF_FFFF, 2'b01, op, pa, ra, dv};
            check(ncap == WR_LEN && cap[61:0] == wf, "R4 write frame",
                  {2'(0), cap[61:0]}, {2'(0), wf});
            check(cmd_rdata == {w[31:17], 1'b1, dv}, "R7 write status word",
                  64'(cmd_rdata), 64'({w[31:17], 1'b1, dv}));
            check(cyc == WR_LEN * 2 * HALF, "R11 write duration",
                  64'(cyc), 64'(WR_LEN * 2 * HALF));
            if (r == 5) check(d0 == 1'b0, "R10 written bit16 ignored", 64'(d0), 64'd0);
        end

        // R9: a second command held on the strobe through a whole read,
        // including the completing edge
        w  = mk_cmd(2'b10, 5'd1, 5'd5, 16'h0);
        w2 = mk_cmd(2'b01, 5'd0, 5'd9, 16'hBEEF);
        @(negedge clk);
        cmd_wdata = w;
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wdata = w2;
        cyc = 0;
        while (!cmd_rdata[16] && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        check(cmd_rdata == {w[31:17], 1'b1, exp_read(5'd1, 5'd5)}, "R9 ignored during read",
              64'(cmd_rdata), 64'({w[31:17], 1'b1, exp_read(5'd1, 5'd5)}));
        @(negedge clk);
        check(cmd_rdata[31:16] == {w2[31:17], 1'b0}, "R10 pending command taken next edge",
              64'(cmd_rdata[31:16]), 64'({w2[31:17], 1'b0}));
        cmd_wr = 1'b0;
        cyc = 0;
        while (!cmd_rdata[16] && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        wf = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd0, 5'd9, 16'hBEEF};
        check(ncap == WR_LEN && cap[61:0] == wf, "R9 following frame is clean",
              {2'(0), cap[61:0]}, {2'(0), wf});
        check(mdc && !mdio_oe, "R1 idle lines after frame",
              64'({mdc, mdio_oe}), 64'h2);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule